// File: doc/BRIEF.md
# Folded SRAM Array Controller

This block is a synthesizable model of a word-organised memory of 2^ADDR_W words, each 2^DATA_LOG2 bits wide. The words are kept in a folded physical array of 2^(ADDR_W-FOLD_LOG2) rows by 2^(DATA_LOG2+FOLD_LOG2) columns. The upper address bits form a row index, and a decoder turns it into a single active wordline. The low FOLD_LOG2 bits form a column-select value. Each output bit has its own multiplexer, which picks that bit from the sensed row.

A read runs as a fixed phase sequence: conditioning, then wordline, then sense. The word is registered as the sense phase ends. A write first drives the data onto the selected columns and then raises the wordline. Only the selected columns of the row take the new value. The controller accepts a new request only while `ready` is high.

Top module: `fsc_top`

## Requirements
- R1: After reset `ready` is 1, `rd_valid` is 0 and `rd_data` is 0.
- R2: The row index is `addr[ADDR_W-1:FOLD_LOG2]`. Exactly one wordline is high during the wordline and sense phases of a read and the drive-commit phase of a write. No wordline is high in any other phase.
- R3: If a read is accepted at clock edge t, `ready` is 0 after edges t to t+2. After edge t+3, `rd_valid` is 1 for exactly one cycle and `ready` is 1 in that same cycle.
- R4: Read data equals the word last written to that address. Output bit j comes from physical column `j*2^FOLD_LOG2 + addr[FOLD_LOG2-1:0]` of the addressed row.
- R5: A write changes only the 2^DATA_LOG2 columns of the addressed word. Every other word, including the others in the same row, keeps its value.
- R6: If a write is accepted at edge t, `ready` is 0 after edges t and t+1 and is 1 again after edge t+2. `rd_valid` stays 0 throughout.
- R7: A request presented while `ready` is 0 is ignored. It leaves memory contents unchanged.
- R8: If `rd_req` and `wr_req` are both 1 in an accepting cycle, only the write is performed and no `rd_valid` pulse follows.
- R9: The wordline rises only after a conditioning phase (read) or a data-drive phase (write). Sense is enabled only after the wordline was already high in the previous cycle.
- R10: A new request may be accepted in the same cycle in which `rd_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_req | input | 1 | Read request, taken when ready is 1 |
| wr_req | input | 1 | Write request, taken when ready is 1; has priority over rd_req |
| addr | input | ADDR_W | Word address (row index above, column select below) |
| wdata | input | 2^DATA_LOG2 | Write data |
| ready | output | 1 | Controller idle and accepting a request |
| rd_valid | output | 1 | One-cycle pulse marking rd_data as valid |
| rd_data | output | 2^DATA_LOG2 | Registered read word |

## Verification
Two things can land in the same cycle: completion of a read (the `rd_valid` pulse) and acceptance of the next request. Reads are chained so that each new request is presented exactly in the cycle where the previous word is delivered. The bench checks that the delivered word is correct and that the chained request runs its full phase timing. A second collision is a read and a write requested together. It is judged by the absence of any `rd_valid` pulse, by the two-cycle write timing, and by reading the written word back afterwards.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_COND  = 3'd1,
    PH_WLINE = 3'd2,
    PH_SENSE = 3'd3,
    PH_DRIVE = 3'd4,
    PH_COMMIT= 3'd5
  } phase_e;
endpackage

// File: rtl/fsc_sequencer.sv
module fsc_sequencer
  import fsc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_req,
  input  logic wr_req,
  output logic ready,
  output logic accept,
  output logic cond_en,
  output logic wl_en,
  output logic sense_en,
  output logic drive_en,
  output logic commit_en
);
  phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_IDLE: begin
        if (wr_req)      ph_d = PH_DRIVE;
        else if (rd_req) ph_d = PH_COND;
      end
      PH_COND:   ph_d = PH_WLINE;
      PH_WLINE:  ph_d = PH_SENSE;
      PH_SENSE:  ph_d = PH_IDLE;
      PH_DRIVE:  ph_d = PH_COMMIT;
      PH_COMMIT: ph_d = PH_IDLE;
      default:   ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign ready     = (ph_q == PH_IDLE);
  assign accept    = ready && (rd_req || wr_req);
  assign cond_en   = (ph_q == PH_COND);
  assign sense_en  = (ph_q == PH_SENSE);
  assign drive_en  = (ph_q == PH_DRIVE) || (ph_q == PH_COMMIT);
  assign commit_en = (ph_q == PH_COMMIT);
  assign wl_en     = (ph_q == PH_WLINE) || (ph_q == PH_SENSE) || (ph_q == PH_COMMIT);

  // R9: wordline follows conditioning or data drive
  a_r9_wl_after_prep: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wl_en) |-> $past(cond_en || drive_en));
  // R9: sense only once the wordline has been up a cycle
  a_r9_sense_late: assert property (@(posedge clk) disable iff (!rst_n)
    sense_en |-> $past(wl_en));
  // R3/R6: an accepted request makes the controller busy
  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);
endmodule

// File: rtl/fsc_row_decoder.sv
module fsc_row_decoder #(
  parameter int ROW_W = 4,
  localparam int ROWS = 1 << ROW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ROW_W-1:0] row_idx,
  output logic [ROWS-1:0]  wl
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign wl[r] = en && (row_idx == ROW_W'(r));
  end

  // R2: never more than one wordline
  a_r2_wl_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wl));
  // R2: exactly one wordline when enabled, none otherwise
  a_r2_wl_count: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(wl) == 1) == en);
endmodule

// File: rtl/fsc_column.sv
module fsc_column #(
  parameter int DATA_LOG2 = 3,
  parameter int FOLD_LOG2 = 2,
  localparam int DATA_W = 1 << DATA_LOG2,
  localparam int FOLD   = 1 << FOLD_LOG2,
  localparam int COLS   = DATA_W * FOLD
) (
  input  logic [FOLD_LOG2-1:0] col_sel,
  input  logic                 drive,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [COLS-1:0]      row_in,
  output logic [COLS-1:0]      col_mask,
  output logic [COLS-1:0]      col_data,
  output logic [DATA_W-1:0]    word
);
  // read side: one FOLD:1 selector per output bit
  for (genvar j = 0; j < DATA_W; j++) begin : g_mux
    logic [FOLD-1:0] grp;
    assign grp     = row_in[j*FOLD +: FOLD];
    assign word[j] = grp[col_sel];
  end

  // write side: column drivers, enabled for the selected interleave slot
  for (genvar c = 0; c < COLS; c++) begin : g_drv
    assign col_mask[c] = drive && (col_sel == FOLD_LOG2'(c % FOLD));
    assign col_data[c] = wdata[c / FOLD];
  end
endmodule

// File: rtl/fsc_array.sv
module fsc_array #(
  parameter int ROW_W = 4,
  parameter int COLS  = 32,
  localparam int ROWS = 1 << ROW_W
) (
  input  logic            clk,
  input  logic [ROWS-1:0] wl,
  input  logic            commit,
  input  logic [COLS-1:0] col_mask,
  input  logic [COLS-1:0] col_data,
  output logic [COLS-1:0] row_out
);
  logic [COLS-1:0] cells [ROWS];

  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if (commit && wl[r])
        cells[r] <= (cells[r] & ~col_mask) | (col_data & col_mask);
    end
  end

  always_comb begin
    row_out = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (wl[r]) row_out = row_out | cells[r];
    end
  end
endmodule

// File: rtl/fsc_top.sv
module fsc_top #(
  parameter int ADDR_W    = 6,
  parameter int DATA_LOG2 = 3,
  parameter int FOLD_LOG2 = 2,
  localparam int DATA_W = 1 << DATA_LOG2,
  localparam int ROW_W  = ADDR_W - FOLD_LOG2,
  localparam int ROWS   = 1 << ROW_W,
  localparam int COLS   = 1 << (DATA_LOG2 + FOLD_LOG2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic accept, cond_en, wl_en, sense_en, drive_en, commit_en;

  fsc_sequencer u_seq (
    .clk(clk), .rst_n(rst_i_n), .rd_req(rd_req), .wr_req(wr_req),
    .ready(ready), .accept(accept), .cond_en(cond_en), .wl_en(wl_en),
    .sense_en(sense_en), .drive_en(drive_en), .commit_en(commit_en)
  );

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;

  always_comb begin
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (accept) begin
      addr_d  = addr;
      wdata_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  logic [ROWS-1:0]   wl;
  logic [COLS-1:0]   row_bits, col_mask, col_data;
  logic [DATA_W-1:0] word;

  fsc_row_decoder #(.ROW_W(ROW_W)) u_dec (
    .clk(clk), .rst_n(rst_i_n), .en(wl_en),
    .row_idx(addr_q[ADDR_W-1:FOLD_LOG2]), .wl(wl)
  );

  fsc_array #(.ROW_W(ROW_W), .COLS(COLS)) u_arr (
    .clk(clk), .wl(wl), .commit(commit_en),
    .col_mask(col_mask), .col_data(col_data), .row_out(row_bits)
  );

  fsc_column #(.DATA_LOG2(DATA_LOG2), .FOLD_LOG2(FOLD_LOG2)) u_col (
    .col_sel(addr_q[FOLD_LOG2-1:0]), .drive(drive_en), .wdata(wdata_q),
    .row_in(row_bits), .col_mask(col_mask), .col_data(col_data), .word(word)
  );

  logic              rd_valid_d;
  logic [DATA_W-1:0] rd_data_d;

  always_comb begin
    rd_valid_d = sense_en;
    rd_data_d  = rd_data;
    if (sense_en) rd_data_d = word;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_valid_d;
      rd_data  <= rd_data_d;
    end
  end

  // R3: valid is a single-cycle pulse
  a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_valid |=> !rd_valid);
  // R3: controller is idle when data is delivered
  a_r3_valid_ready: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_valid |-> ready);
  // R7: latched address holds while busy
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    !ready |=> $stable(addr_q));
  // R8: write wins over read
  a_r8_write_priority: assert property (@(posedge clk) disable iff (!rst_i_n)
    (accept && wr_req) |=> drive_en);
endmodule

// File: tb/sim_fsc_top.sv
module sim_fsc_top;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int NW = 1 << AW;

  logic clk, rst_n, rd_req, wr_req;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic ready, rd_valid;
  logic [DW-1:0] rd_data;

  int n_chk, n_bad;
  logic [DW-1:0] ref_mem [NW];

  fsc_top u0 (.clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
              .addr(addr), .wdata(wdata), .ready(ready), .rd_valid(rd_valid),
              .rd_data(rd_data));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input int a, input int d, input bit tchk);
    @(negedge clk);
    wr_req = 1'b1; addr = AW'(a); wdata = DW'(d);
    @(negedge clk);
    wr_req = 1'b0;
    if (tchk) chk(ready == 1'b0, "R6 busy after write edge t", ready, 0);
    @(negedge clk);
    if (tchk) chk(ready == 1'b0 && rd_valid == 1'b0, "R6 busy at t+1", ready, 0);
    @(negedge clk);
    if (tchk) chk(ready == 1'b1 && rd_valid == 1'b0, "R6 ready at t+2", ready, 1);
    ref_mem[a] = DW'(d);
  endtask

  // starts a read at the current state of the bench (ready expected 1)
  task automatic do_read(input int a, input bit tchk);
    @(negedge clk);
    rd_req = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_req = 1'b0;
    if (tchk) chk(ready == 1'b0, "R3 busy after t", ready, 0);
    @(negedge clk);
    @(negedge clk);
    if (tchk) chk(rd_valid == 1'b0 && ready == 1'b0, "R3 no valid at t+2", rd_valid, 0);
    @(negedge clk);
    chk(rd_valid == 1'b1, "R3 valid at t+3", rd_valid, 1);
    chk(ready == 1'b1, "R3 ready with valid", ready, 1);
    chk(rd_data == ref_mem[a], "R4 R5 read data", rd_data, ref_mem[a]);
    @(negedge clk);
    if (tchk) chk(rd_valid == 1'b0, "R3 one-cycle pulse", rd_valid, 0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rd_req = 0; wr_req = 0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(ready == 1'b1, "R1 ready", ready, 1);
    chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    chk(rd_data == '0, "R1 rd_data", rd_data, 0);

    // fill every word, then read all back (R4, R2 row/column split)
    for (int a = 0; a < NW; a++) do_write(a, (a * 37 + 5) & 8'hFF, a < 4);
    for (int a = 0; a < NW; a++) do_read(a, a < 4);

    // R5: rewrite one slot per row, neighbours in the row must survive
    for (int r = 0; r < NW / 4; r++) do_write(r * 4 + (r % 4), ~((r * 11) & 8'hFF), 1'b0);
    for (int a = 0; a < NW; a++) do_read(a, 1'b0);

    // R7: request during busy write is ignored
    @(negedge clk);
    wr_req = 1'b1; addr = AW'(5); wdata = 8'h5A;
    @(negedge clk);
    addr = AW'(6); wdata = 8'hA5;          // busy: must be dropped
    @(negedge clk);
    wr_req = 1'b0;
    @(negedge clk);
    ref_mem[5] = 8'h5A;
    chk(ready == 1'b1, "R7 ready after write", ready, 1);
    do_read(6, 1'b0);
    do_read(5, 1'b0);

    // R8: simultaneous read and write -> write only
    @(negedge clk);
    rd_req = 1'b1; wr_req = 1'b1; addr = AW'(9); wdata = 8'h3C;
    @(negedge clk);
    rd_req = 1'b0; wr_req = 1'b0;
    chk(ready == 1'b0 && rd_valid == 1'b0, "R8 busy, no valid t", rd_valid, 0);
    @(negedge clk);
    chk(ready == 1'b0 && rd_valid == 1'b0, "R8 busy, no valid t+1", rd_valid, 0);
    @(negedge clk);
    chk(ready == 1'b1 && rd_valid == 1'b0, "R8 ready at t+2", ready, 1);
    @(negedge clk);
    chk(rd_valid == 1'b0, "R8 no late valid", rd_valid, 0);
    ref_mem[9] = 8'h3C;
    do_read(9, 1'b0);

    // R10: chained reads, next request in the valid cycle
    @(negedge clk);
    rd_req = 1'b1; addr = AW'(0);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      rd_req = 1'b0;
      chk(ready == 1'b0, "R10 chained accept", ready, 0);
      repeat (2) @(negedge clk);
      @(negedge clk);
      chk(rd_valid == 1'b1, "R10 valid", rd_valid, 1);
      chk(rd_data == ref_mem[i * 3], "R10 chained data", rd_data, ref_mem[i * 3]);
      if (i < 15) begin
        rd_req = 1'b1; addr = AW'((i + 1) * 3);
      end
    end
    @(negedge clk);
    chk(rd_valid == 1'b0, "R10 final pulse ends", rd_valid, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule